// File: doc/BRIEF.md
# Payload Allocation Table Shadow/Active Commit Block

This block sits in the register space of a multi-stream display link receiver. Software fills a shadow copy of an eight-word virtual-channel payload allocation table through a simple register write port. The block keeps a separate active copy that feeds the downstream stream demultiplexer. From the first active word it presents four 4-bit stream payload IDs and the framing mode (multi-stream or single-stream).

The shadow table moves into the active copy as one unit, in one of two ways. A force command commits it at once. An update request commits it at the next allocation-change-trigger (ACT) event, which the link layer signals with a one-cycle strobe. A sticky acknowledge bit in a read-only status register reports that the requested commit has taken place. The bit stays set while the request is held and clears when software withdraws the request. Detecting the ACT pattern in the link symbols is outside this block.

Top module: `vcpt_commit_top`

Register map (word addresses): table words 0..7 at 0x90..0x97, control at 0xA0, status at 0xA1.

## Requirements
- R1: After a synchronous active-low reset, every shadow and active table word is zero, `mst_mode` is 0, all stream IDs are 0, and the control register (0xA0) and status register (0xA1) read 0x00000000.
- R2: Table word 0 keeps only bit 0 and bits 19:4; its bits 31:20 and 3:1 read as zero. Table words 1..7 keep bits 29:0; their bits 31:30 read as zero. A read of 0x90+k returns shadow word k.
- R3: `mst_mode` equals bit 0 of active word 0 (1 selects multi-stream framing, 0 selects single-stream framing). `stream_id` bits [4s+3:4s] equal bits [4s+7:4s+4] of active word 0, for s = 0..3.
- R4: A write to the shadow table leaves the active table (`act_table`, `mst_mode`, `stream_id`) unchanged until a commit occurs.
- R5: A write to control with bit 0 = 1 (force) copies all eight shadow words to the active table on that write's clock edge. Bit 0 is not stored and reads back as 0.
- R6: Control bit 1 (request) is a stored level that reads back. When request is written from 0 to 1, a commit is armed. The next ACT strobe then copies all eight shadow words to the active table on that strobe's clock edge.
- R7: Status bit 30 (acknowledge) becomes 1 on the clock edge of the ACT strobe that performs an armed commit. All other status bits read 0.
- R8: Writing control with bit 1 = 0 clears the acknowledge bit and any armed commit on that write's edge. Acknowledge is never 1 while request is 0.
- R9: Only one ACT commit happens per request assertion. While request stays 1 after a commit, further ACT strobes change neither the active table nor acknowledge (which stays 1).
- R10: A single control write with both bits set commits at once. It also arms a request, so the next ACT strobe commits the shadow contents again and sets acknowledge.
- R11: An ACT strobe with no armed request has no effect on the active table or on status.
- R12: Writes to the status address or to any unmapped address change no register. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read word address |
| rd_data | output | 32 | Combinational read data for `rd_addr` |
| act_seen | input | 1 | One-cycle ACT-detected strobe |
| mst_mode | output | 1 | Active framing mode, 1 = multi-stream |
| stream_id | output | 16 | Four active 4-bit stream payload IDs, stream 0 in bits 3:0 |
| act_table | output | 256 | All eight active words, word k in bits [32k+31:32k] |

## Verification
The assertions check on every cycle that the active copy holds still unless a commit is signalled, and that a commit loads exactly the previous shadow contents. They also check that acknowledge never stands without a request, that acknowledge only rises after an ACT strobe that met an armed request, and that an acknowledged request is never still armed. The bench scenarios are needed for the value-level behaviour: field masking and readback, the mapping of active word 0 onto the mode and stream ID outputs, the single commit per request when the shadow changes after the first ACT, the combined force-and-request write, and the ignored writes to the status address and to unmapped addresses.

// File: rtl/vcpt_pkg.sv
// Package: shared sizes, register addresses and per-word field masks for the
// payload allocation table commit block.
// Assumes: 32-bit register words and a word-addressed register port.
package vcpt_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned N_WORDS   = 8;
    localparam int unsigned N_STREAMS = 4;
    localparam int unsigned ID_W      = 4;
    localparam int unsigned ADDR_W    = 8;

    localparam logic [ADDR_W-1:0] TAB_BASE  = 8'h90;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'hA0;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 8'hA1;

    localparam int unsigned CTRL_FORCE_BIT = 0;
    localparam int unsigned CTRL_REQ_BIT   = 1;
    localparam int unsigned STAT_ACK_BIT   = 30;
    localparam int unsigned MODE_BIT       = 0;
    localparam int unsigned ID_LSB         = 4;

    // Bits a table word keeps; everything else is stored and read as zero.
    function automatic logic [WORD_W-1:0] word_keep(input int unsigned k);
        logic [WORD_W-1:0] m;
        if (k == 0) begin
            m = '0;
            m[MODE_BIT] = 1'b1;
            for (int unsigned b = ID_LSB; b < ID_LSB + N_STREAMS * ID_W; b++) begin
                m[b] = 1'b1;
            end
        end else begin
            m = {2'b00, {(WORD_W-2){1'b1}}};
        end
        return m;
    endfunction

endpackage

// File: rtl/vcpt_shadow_regs.sv
// Module: software-written shadow copy of the payload allocation table.
// What it does: stores one masked word per table index on a decoded write.
// Assumes: wr_sel is already qualified by the address decoder (one word at
// most per cycle); reserved bits are dropped at write time.
module vcpt_shadow_regs #(
    parameter int unsigned N_WORDS = vcpt_pkg::N_WORDS,
    parameter int unsigned WORD_W  = vcpt_pkg::WORD_W,
    localparam int unsigned IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_sel,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [WORD_W-1:0]           wr_data,
    output logic [N_WORDS*WORD_W-1:0]   shadow
);

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        localparam logic [WORD_W-1:0] KEEP = vcpt_pkg::word_keep(g);
        logic [WORD_W-1:0] word_q;
        logic              hit;

        // Purpose: decode whether this word is the write target.
        always_comb begin
            hit = wr_sel && (wr_idx == IDX_W'(g));
        end

        // Purpose: hold the masked shadow word, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (hit) begin
                word_q <= wr_data & KEEP;
            end
        end

        assign shadow[g*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/vcpt_commit_ctrl.sv
// Module: commit sequencing for the payload table.
// What it does: turns control writes and the ACT strobe into a single-cycle
// commit pulse, keeps the request level, the armed flag and the sticky
// acknowledge bit.
// Assumes: act_seen is a clean one-cycle strobe in this clock domain; the
// control write arrives as decoded force/request bits with ctrl_wr.
module vcpt_commit_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_force,
    input  logic ctrl_req,
    input  logic act_seen,
    output logic req_q,
    output logic ack_q,
    output logic commit
);

    logic armed_q;
    logic force_now;
    logic act_commit;
    logic req_rise;
    logic req_drop;

    // Purpose: classify this cycle's control write and ACT strobe.
    always_comb begin
        force_now  = ctrl_wr && ctrl_force;
        req_rise   = ctrl_wr && ctrl_req && !req_q;
        req_drop   = ctrl_wr && !ctrl_req;
        act_commit = act_seen && armed_q && !req_drop;
        commit     = force_now || act_commit;
    end

    // Purpose: request level as last written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (ctrl_wr) begin
            req_q <= ctrl_req;
        end
    end

    // Purpose: armed flag, set by a new request, spent by one ACT commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (req_drop) begin
            armed_q <= 1'b0;
        end else if (req_rise) begin
            armed_q <= 1'b1;
        end else if (act_commit) begin
            armed_q <= 1'b0;
        end
    end

    // Purpose: sticky acknowledge, set by the ACT commit, cleared with the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else if (req_drop) begin
            ack_q <= 1'b0;
        end else if (act_commit) begin
            ack_q <= 1'b1;
        end
    end

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> req_q); // R8

    AST_ACK_FROM_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> $past(act_seen && armed_q)); // R7

    AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> !armed_q); // R9

    AST_IDLE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (act_seen && !armed_q && !ctrl_wr) |-> !commit); // R11

endmodule

// File: rtl/vcpt_active_regs.sv
// Module: active copy of the payload allocation table.
// What it does: loads every shadow word at once on a commit pulse and holds
// otherwise.
// Assumes: commit is a single-cycle pulse from the commit controller and the
// shadow words are already masked.
module vcpt_active_regs #(
    parameter int unsigned N_WORDS = vcpt_pkg::N_WORDS,
    parameter int unsigned WORD_W  = vcpt_pkg::WORD_W,
    localparam int unsigned TOT_W  = N_WORDS * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [TOT_W-1:0] shadow,
    output logic [TOT_W-1:0] active
);

    // Purpose: whole-table load on commit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
        end else if (commit) begin
            active <= shadow;
        end
    end

    AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active)); // R4

    AST_COMMIT_LOADS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (active == $past(shadow))); // R5

endmodule

// File: rtl/vcpt_commit_top.sv
// Module: payload allocation table register block with shadow/active commit.
// What it does: decodes the register port, holds the shadow table, commits it
// to the active table by force or at the next ACT after a request, and
// presents the framing mode, stream IDs and status readback.
// Assumes: one write per cycle; reads are combinational and side-effect free.
module vcpt_commit_top #(
    parameter int unsigned N_WORDS   = vcpt_pkg::N_WORDS,
    parameter int unsigned WORD_W    = vcpt_pkg::WORD_W,
    parameter int unsigned ADDR_W    = vcpt_pkg::ADDR_W,
    parameter int unsigned N_STREAMS = vcpt_pkg::N_STREAMS,
    parameter int unsigned ID_W      = vcpt_pkg::ID_W,
    localparam int unsigned IDX_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int unsigned TOT_W    = N_WORDS * WORD_W,
    localparam int unsigned SID_W    = N_STREAMS * ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              act_seen,
    output logic              mst_mode,
    output logic [SID_W-1:0]  stream_id,
    output logic [TOT_W-1:0]  act_table
);

    import vcpt_pkg::*;

    logic [ADDR_W-1:0] wr_off;
    logic [ADDR_W-1:0] rd_off;
    logic              wr_tab;
    logic              wr_ctrl;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic              rd_tab;
    logic [TOT_W-1:0]  shadow;
    logic              req_q;
    logic              ack_q;
    logic              commit;

    // Purpose: write address decode into table index or control register.
    always_comb begin
        wr_off  = wr_addr - TAB_BASE;
        wr_tab  = wr_en && (wr_addr >= TAB_BASE) && (wr_off < ADDR_W'(N_WORDS));
        wr_idx  = wr_off[IDX_W-1:0];
        wr_ctrl = wr_en && (wr_addr == CTRL_ADDR);
    end

    vcpt_shadow_regs #(
        .N_WORDS (N_WORDS),
        .WORD_W  (WORD_W)
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_tab),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .shadow  (shadow)
    );

    vcpt_commit_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (wr_ctrl),
        .ctrl_force (wr_data[CTRL_FORCE_BIT]),
        .ctrl_req   (wr_data[CTRL_REQ_BIT]),
        .act_seen   (act_seen),
        .req_q      (req_q),
        .ack_q      (ack_q),
        .commit     (commit)
    );

    vcpt_active_regs #(
        .N_WORDS (N_WORDS),
        .WORD_W  (WORD_W)
    ) u_active (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .shadow  (shadow),
        .active  (act_table)
    );

    // Purpose: framing mode from active word 0.
    always_comb begin
        mst_mode = act_table[MODE_BIT];
    end

    // Purpose: per-stream payload IDs from active word 0.
    for (genvar s = 0; s < N_STREAMS; s++) begin : g_sid
        assign stream_id[s*ID_W +: ID_W] = act_table[ID_LSB + s*ID_W +: ID_W];
    end

    // Purpose: read address decode.
    always_comb begin
        rd_off = rd_addr - TAB_BASE;
        rd_tab = (rd_addr >= TAB_BASE) && (rd_off < ADDR_W'(N_WORDS));
        rd_idx = rd_off[IDX_W-1:0];
    end

    // Purpose: readback multiplexer for shadow, control and status.
    always_comb begin
        rd_data = '0;
        if (rd_tab) begin
            rd_data = shadow[rd_idx*WORD_W +: WORD_W];
        end else if (rd_addr == CTRL_ADDR) begin
            rd_data[CTRL_REQ_BIT] = req_q;
        end else if (rd_addr == STAT_ADDR) begin
            rd_data[STAT_ACK_BIT] = ack_q;
        end
    end

    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == STAT_ADDR) && !act_seen) |=> $stable(ack_q)); // R12

endmodule

// File: tb/sim_vcpt_commit_top.sv
module sim_vcpt_commit_top;

    localparam int NW = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [7:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic         act_seen = 1'b0;
    logic         mst_mode;
    logic [15:0]  stream_id;
    logic [255:0] act_table;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] sh_m [NW];
    logic [31:0] ac_m [NW];

    always #2 clk = ~clk;

    vcpt_commit_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .act_seen  (act_seen),
        .mst_mode  (mst_mode),
        .stream_id (stream_id),
        .act_table (act_table)
    );

    function automatic logic [31:0] keep(input int k);
        return (k == 0) ? 32'h000F_FFF1 : 32'h3FFF_FFFF;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic tab_wr(input int k, input logic [31:0] d);
        bus_wr(8'h90 + 8'(k), d);
        sh_m[k] = d & keep(k);
    endtask

    task automatic pulse_act();
        @(negedge clk);
        act_seen = 1'b1;
        @(negedge clk);
        act_seen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic model_commit();
        for (int k = 0; k < NW; k++) ac_m[k] = sh_m[k];
    endtask

    task automatic chk_active(input string tag);
        for (int k = 0; k < NW; k++) chk(tag, act_table[k*32 +: 32], ac_m[k]);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NW; k++) begin sh_m[k] = '0; ac_m[k] = '0; end
        chk_active("R1 active");
        chk("R1 mode", {31'b0, mst_mode}, 32'h0);
        chk("R1 ids", {16'b0, stream_id}, 32'h0);
        rd(8'hA0, d); chk("R1 ctrl", d, 32'h0);
        rd(8'hA1, d); chk("R1 status", d, 32'h0);
        rd(8'h93, d); chk("R1 shadow", d, 32'h0);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        tab_wr(0, 32'hFFFF_FFFF);
        tab_wr(5, 32'hFFFF_FFFF);
        rd(8'h90, d); chk("R2 word0 mask", d, 32'h000F_FFF1);
        rd(8'h95, d); chk("R2 word5 mask", d, 32'h3FFF_FFFF);
        chk_active("R4 shadow write no effect");
    endtask

    task automatic t_force();
        logic [31:0] d;
        tab_wr(0, 32'hABC4_321F);
        bus_wr(8'hA0, 32'h1);
        model_commit();
        chk_active("R5 force commit");
        chk("R3 mode", {31'b0, mst_mode}, 32'h1);
        chk("R3 ids", {16'b0, stream_id}, 32'h0000_4321);
        rd(8'hA0, d); chk("R5 force self-clear", d, 32'h0);
        rd(8'hA1, d); chk("R7 no ack on force", d, 32'h0);
    endtask

    task automatic t_idle_act();
        logic [31:0] d;
        tab_wr(1, 32'h1234_5678);
        tab_wr(0, 32'h0000_0000);
        pulse_act();
        chk_active("R11 idle act");
        rd(8'hA1, d); chk("R11 status", d, 32'h0);
    endtask

    task automatic t_request();
        logic [31:0] d;
        bus_wr(8'hA0, 32'h2);
        rd(8'hA0, d); chk("R6 req readback", d, 32'h2);
        rd(8'hA1, d); chk("R6 ack before act", d, 32'h0);
        chk_active("R6 waits for act");
        pulse_act();
        model_commit();
        chk_active("R6 act commit");
        chk("R3 mode sst", {31'b0, mst_mode}, 32'h0);
        rd(8'hA1, d); chk("R7 ack set", d, 32'h4000_0000);
    endtask

    task automatic t_one_shot();
        logic [31:0] d;
        tab_wr(1, 32'h0000_00AA);
        pulse_act();
        chk_active("R9 no second commit");
        rd(8'hA1, d); chk("R9 ack held", d, 32'h4000_0000);
        bus_wr(8'hA0, 32'h0);
        rd(8'hA1, d); chk("R8 ack cleared", d, 32'h0);
        rd(8'hA0, d); chk("R8 req cleared", d, 32'h0);
        pulse_act();
        chk_active("R8 disarmed");
    endtask

    task automatic t_both();
        logic [31:0] d;
        tab_wr(2, 32'h0000_0055);
        bus_wr(8'hA0, 32'h3);
        model_commit();
        chk_active("R10 immediate");
        rd(8'hA1, d); chk("R10 no ack yet", d, 32'h0);
        tab_wr(2, 32'h0000_0066);
        pulse_act();
        model_commit();
        chk_active("R10 act recommit");
        rd(8'hA1, d); chk("R10 ack", d, 32'h4000_0000);
        bus_wr(8'hA0, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_wr(8'hA1, 32'hFFFF_FFFF);
        rd(8'hA1, d); chk("R12 status ro", d, 32'h0);
        bus_wr(8'h98, 32'hFFFF_FFFF);
        bus_wr(8'h8F, 32'hFFFF_FFFF);
        for (int k = 0; k < NW; k++) begin
            rd(8'h90 + 8'(k), d); chk("R12 table untouched", d, sh_m[k]);
        end
        rd(8'h98, d); chk("R12 unmapped read", d, 32'h0);
        rd(8'hA0, d); chk("R12 ctrl untouched", d, 32'h0);
        chk_active("R12 active untouched");
    endtask

    initial begin
        t_reset();
        t_layout();
        t_force();
        t_idle_act();
        t_request();
        t_one_shot();
        t_both();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule